// File: doc/BRIEF.md
# Memory-Mapped Serial Transmit Port

This block sits on a simple word-addressed CPU bus. It presents four 32-bit register slots for a serial channel that can only transmit. A receive status word and a receive data word take two of the slots. They are kept so that a receiver can be added later. The other two slots are the transmit status word and the transmit data word.

When software writes the transmit data slot, the least significant byte of the written word goes into a one-byte holding register. That register offers the byte to a downstream byte sink through a valid/ready handshake. The sink does the bit-level serialization, which lies outside this block.

Each status word has two fields:
- a ready flag, where high means ready;
- an interrupt-enable bit that software can read and write.

The block drives one interrupt line. The line is high when transmit interrupts are enabled and the transmitter can take another byte.

Top module: `serport_tx_top`

## Requirements
- R1: Only address bits [3:2] select a slot: 0 is receive status, 1 is receive data, 2 is transmit status and 3 is transmit data. All other address bits are ignored, so for example address 0x10 aliases 0x00 and 0x38 aliases 0x08. A read of the transmit data slot returns zero.
- R2: A synchronous active-high reset clears both interrupt-enable bits and empties the holding register. After reset, tx_valid and irq are 0, the transmit status reads 0x1 and the receive status reads 0x0.
- R3: A write to either status slot loads only bit 1 (interrupt enable) from the written word. Every other bit of that status word is left unchanged.
- R4: A write to the transmit data slot that is accepted drives tx_valid high in the following cycle, with tx_data equal to bits [7:0] of the written word. Bits [31:8] are ignored.
- R5: The transmit status word reads the ready flag in bit 0 and interrupt enable in bit 1. The ready flag is high when tx_ready is high or the holding register is empty. When the register is full and tx_ready is high in the same cycle as a write, the new byte replaces the byte being consumed.
- R6: A transmit data write made while the ready flag is low is dropped. The byte already held is kept.
- R7: While tx_valid is high and tx_ready is low, tx_valid and tx_data stay stable. Once a cycle with tx_ready high ends and no new write arrives, tx_valid is low.
- R8: The receive data slot always reads zero, and writes to it have no effect. Bit 0 of the receive status word always reads 0.
- R9: irq is high exactly when the transmit interrupt enable is set and the transmit ready flag is high. The receive interrupt enable does not drive irq.
- R10: bus_rdata is registered. It carries the selected slot in the cycle after a cycle with bus_re high, and it is zero after a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; only bits [3:2] are decoded |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| tx_data | output | 8 | Byte offered to the sink |
| tx_valid | output | 1 | Byte on tx_data is valid |
| tx_ready | input | 1 | Sink accepts the byte this cycle |
| irq | output | 1 | Transmit interrupt request |

## Verification
A wrong internal state shows at the ports within one or two cycles.

- A stuck holding-register flag appears on tx_valid at the next edge. It also flips bit 0 of the transmit status word and the irq line.
- A corrupted interrupt-enable bit shows on irq at once. It also appears in bit 1 of the status read in the cycle after the read strobe.
- A decode error appears as a wrong value on the first read of the affected slot, or as a status change after a write that should have had no effect.

The bench reads each status word back after every write that could disturb it.

// File: rtl/serport_pkg.sv
package serport_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int RDY_BIT = 0;
    localparam int IE_BIT = 1;
    localparam int N_CHAN = 2;

    typedef enum logic [1:0] {
        SLOT_RX_STAT = 2'd0,
        SLOT_RX_DATA = 2'd1,
        SLOT_TX_STAT = 2'd2,
        SLOT_TX_DATA = 2'd3
    } slot_e;

    typedef struct packed {
        logic               wr;
        logic               rd;
        slot_e              slot;
        logic [WORD_W-1:0]  wdata;
    } bus_req_t;

    function automatic logic [WORD_W-1:0] status_word(input logic ready, input logic ie);
        logic [WORD_W-1:0] w;
        w = '0;
        w[RDY_BIT] = ready;
        w[IE_BIT] = ie;
        return w;
    endfunction

    function automatic slot_e chan_slot(input int ch);
        return (ch == 0) ? SLOT_RX_STAT : SLOT_TX_STAT;
    endfunction

endpackage

// File: rtl/serport_decode.sv
module serport_decode
    import serport_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    input  logic [WORD_W-1:0] wdata,
    output bus_req_t          req
);
    logic unused_addr_bits;
    assign unused_addr_bits = ^{addr[ADDR_W-1:4], addr[1:0]};

    always_comb begin
        req.wr    = we;
        req.rd    = re;
        req.slot  = slot_e'(addr[3:2]);
        req.wdata = wdata;
    end
endmodule

// File: rtl/serport_txbuf.sv
module serport_txbuf
    import serport_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_byte,
    input  logic         tx_ready,
    output logic         tx_valid,
    output logic [W-1:0] tx_data,
    output logic         can_take
);
    logic         full_q;
    logic [W-1:0] byte_q;

    assign can_take = tx_ready | ~full_q;
    assign tx_valid = full_q;
    assign tx_data  = byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            byte_q <= '0;
        end else if (load && can_take) begin
            full_q <= 1'b1;
            byte_q <= load_byte;
        end else if (tx_ready) begin
            full_q <= 1'b0;
        end
    end
endmodule

// File: rtl/serport_regs.sv
module serport_regs
    import serport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              tx_can_take,
    output logic [WORD_W-1:0] rdata,
    output logic              tx_ie,
    output logic              tx_push
);
    logic [N_CHAN-1:0] ie_q;
    logic [N_CHAN-1:0] chan_rdy;
    logic unused_wdata_bits;

    assign unused_wdata_bits = ^{req.wdata[WORD_W-1:IE_BIT+1], req.wdata[IE_BIT-1:0]};
    assign chan_rdy = {tx_can_take, 1'b0};

    generate
        for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
            always_ff @(posedge clk) begin
                if (rst) begin
                    ie_q[ch] <= 1'b0;
                end else if (req.wr && req.slot == chan_slot(ch)) begin
                    ie_q[ch] <= req.wdata[IE_BIT];
                end
            end
        end
    endgenerate

    assign tx_ie   = ie_q[1];
    assign tx_push = req.wr && (req.slot == SLOT_TX_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (req.rd) begin
            unique case (req.slot)
                SLOT_RX_STAT: rdata <= status_word(chan_rdy[0], ie_q[0]);
                SLOT_TX_STAT: rdata <= status_word(chan_rdy[1], ie_q[1]);
                default:      rdata <= '0;
            endcase
        end else begin
            rdata <= '0;
        end
    end
endmodule

// File: rtl/serport_tx_top.sv
module serport_tx_top
    import serport_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              irq
);
    bus_req_t req;
    logic     can_take;
    logic     tx_ie;
    logic     tx_push;

    serport_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr  (bus_addr),
        .we    (bus_we),
        .re    (bus_re),
        .wdata (bus_wdata),
        .req   (req)
    );

    serport_regs i_regs (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .tx_can_take (can_take),
        .rdata       (bus_rdata),
        .tx_ie       (tx_ie),
        .tx_push     (tx_push)
    );

    serport_txbuf #(.W(BYTE_W)) i_txbuf (
        .clk       (clk),
        .rst       (rst),
        .load      (tx_push),
        .load_byte (req.wdata[BYTE_W-1:0]),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .can_take  (can_take)
    );

    assign irq = tx_ie & can_take;
endmodule

// File: rtl/serport_tx_chk.sv
module serport_tx_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic [7:0]        tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              irq
);
    // R4: accepted data write shows its low byte next cycle
    p_write_loads_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr[3:2] == 2'b11 && (tx_ready || !tx_valid))
        |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));

    // R6: write while blocked is dropped
    p_drop_blocked_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr[3:2] == 2'b11 && tx_valid && !tx_ready)
        |=> (tx_valid && $stable(tx_data)));

    // R7: held byte stays until taken
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R9: interrupt only when the channel can take a byte
    p_irq_ready_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (tx_ready || !tx_valid));

    // R8: receive data slot reads zero
    p_rx_data_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr[3:2] == 2'b01) |=> (bus_rdata == 32'h0));

    // R10: no read strobe gives zero read data
    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> (bus_rdata == 32'h0));
endmodule

bind serport_tx_top serport_tx_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .irq       (irq)
);

// File: tb/test_serport_tx_top.sv
module test_serport_tx_top;
    localparam int ADDR_W = 32;
    localparam int NV = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [31:0]       bus_rdata;
    logic [7:0]        tx_data;
    logic              tx_valid;
    logic              tx_ready = 1'b1;
    logic              irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    serport_tx_top #(.ADDR_W(ADDR_W)) i_serport_tx_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq)
    );

    // {write, addr[7:0], wdata, expected read}; writes carry no expectation
    localparam logic [72:0] VEC [NV] = '{
        {1'b0, 8'h00, 32'h0000_0000, 32'h0000_0000},
        {1'b0, 8'h08, 32'h0000_0000, 32'h0000_0001},
        {1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0000_0000},
        {1'b0, 8'h08, 32'h0000_0000, 32'h0000_0003},
        {1'b1, 8'h00, 32'hFFFF_FFFD, 32'h0000_0000},
        {1'b0, 8'h00, 32'h0000_0000, 32'h0000_0000},
        {1'b1, 8'h00, 32'h0000_0002, 32'h0000_0000},
        {1'b0, 8'h00, 32'h0000_0000, 32'h0000_0002},
        {1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0000_0000},
        {1'b0, 8'h04, 32'h0000_0000, 32'h0000_0000},
        {1'b0, 8'h00, 32'h0000_0000, 32'h0000_0002},
        {1'b0, 8'h10, 32'h0000_0000, 32'h0000_0002},
        {1'b0, 8'h0C, 32'h0000_0000, 32'h0000_0000},
        {1'b1, 8'h08, 32'h0000_0000, 32'h0000_0000},
        {1'b0, 8'h08, 32'h0000_0000, 32'h0000_0001},
        {1'b0, 8'h38, 32'h0000_0000, 32'h0000_0001}
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = {{(ADDR_W-8){1'b0}}, a}; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = {{(ADDR_W-8){1'b0}}, a};
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(tx_valid == 1'b0, "R2 tx_valid after reset", {31'b0, tx_valid}, 32'h0);
        check(irq == 1'b0, "R2 irq after reset", {31'b0, irq}, 32'h0);

        // table walk: R1 decode, R3 status writes, R8 receive slots
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) begin
                do_write(VEC[i][71:64], VEC[i][63:32]);
            end else begin
                do_read(VEC[i][71:64], rd);
                check(rd == VEC[i][31:0], $sformatf("R1 R3 R8 table vector %0d", i), rd, VEC[i][31:0]);
            end
        end

        // R10: idle cycle returns zero
        do_read(8'h08, rd);
        @(negedge clk);
        check(bus_rdata == 32'h0, "R10 rdata idle", bus_rdata, 32'h0);

        // R4: byte load with sink stalled
        tx_ready = 1'b0;
        do_write(8'h0C, 32'hABCD_EF5A);
        check(tx_valid == 1'b1, "R4 tx_valid", {31'b0, tx_valid}, 32'h1);
        check(tx_data == 8'h5A, "R4 tx_data low byte", {24'b0, tx_data}, 32'h5A);
        // R5: not ready while full and stalled
        do_read(8'h08, rd);
        check(rd == 32'h0, "R5 status full", rd, 32'h0);
        // R6: blocked write dropped
        do_write(8'h0C, 32'h0000_0011);
        check(tx_data == 8'h5A, "R6 dropped write", {24'b0, tx_data}, 32'h5A);
        // R7: hold while stalled
        repeat (3) @(negedge clk);
        check(tx_valid && tx_data == 8'h5A, "R7 hold", {23'b0, tx_valid, tx_data}, 32'h15A);
        tx_ready = 1'b1;
        @(negedge clk);
        check(tx_valid == 1'b0, "R7 released", {31'b0, tx_valid}, 32'h0);

        // R9: interrupt follows enable and readiness
        do_write(8'h08, 32'h0000_0002);
        check(irq == 1'b1, "R9 irq enabled ready", {31'b0, irq}, 32'h1);
        tx_ready = 1'b0;
        do_write(8'h0C, 32'h0000_0077);
        check(irq == 1'b0, "R9 irq full", {31'b0, irq}, 32'h0);
        tx_ready = 1'b1;
        #1;
        check(irq == 1'b1, "R9 irq sink ready", {31'b0, irq}, 32'h1);
        // R5: replace byte while sink consumes
        do_write(8'h0C, 32'h0000_0099);
        check(tx_valid && tx_data == 8'h99, "R5 replace", {23'b0, tx_valid, tx_data}, 32'h199);
        @(negedge clk);
        check(tx_valid == 1'b0, "R7 drained", {31'b0, tx_valid}, 32'h0);

        // R2: reset mid-run clears everything
        tx_ready = 1'b0;
        do_write(8'h0C, 32'h0000_0033);
        do_write(8'h00, 32'h0000_0002);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        tx_ready = 1'b1;
        #1;
        check(tx_valid == 1'b0 && irq == 1'b0, "R2 reset outputs", {30'b0, tx_valid, irq}, 32'h0);
        do_read(8'h08, rd);
        check(rd == 32'h1, "R2 tx status reset", rd, 32'h1);
        do_read(8'h00, rd);
        check(rd == 32'h0, "R2 rx status reset", rd, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule